// File: doc/BRIEF.md
# Stereo Audio Sample FIFO Pair

This block buffers 24-bit audio samples between a host and the serial side of a digital audio interface, in both directions. Each direction has a left queue and a right queue. They are meant to move together, one stereo sample at a time, but each has its own port so that a missing or extra sample can be seen. On the transmit side the host writes samples and the serial engine pops them. On the receive side the serial engine pushes samples and the host reads them.

Occupancy is compared against a selectable threshold to give a transmit-low indication and a receive-high indication. Each indication can also raise a DMA request when that request is enabled. Control inputs select the following modes:
- silence the transmit output without consuming samples,
- collapse a queue to a single remaining sample,
- stop the receive queues from accepting serial data,
- mask host reads to zero.

When automatic alignment is enabled and the left and right queues drift apart, the deeper queue is cut back to match the shallower one.

Top module: `stereo_sample_fifo`

## Requirements
- R1: After reset, every queue is empty. Both serial transmit outputs and both host receive outputs read zero. `tx_empty` is 1, and `rx_full`, both error pulses and both resync pulses are 0.
- R2: Each queue returns its 24-bit samples in the order they were written. Left and right are independent. A pop or host read loads the sample onto the data output at the clock edge that accepts it, so the sample is visible from the following cycle.
- R3: `tx_empty` is high when both transmit queues hold no more than 0, 4, 8 or 12 samples, for `tx_empty_sel` values 0, 1, 2 and 3 respectively.
- R4: `rx_full` is high when both receive queues hold at least 1, 4, 8 or 16 samples, for `rx_full_sel` values 0, 1, 2 and 3 respectively.
- R5: Each queue holds 16 samples.
  - A push into a full queue is discarded.
  - A pop from an empty queue yields zero.
  - Either event produces a one-cycle pulse on that direction's `*_unov` output in the following cycle.
- R6: `tx_mode` encoding:
  - 1 is normal operation.
  - 0 and 3 make every serial pop return zero without consuming a sample or flagging underrun.
  - 2 collapses both transmit queues to one sample each, keeping the oldest, and ignores pushes and pops in that cycle.
- R7: While `rx_trim` is high, both receive queues are collapsed to one sample each, keeping the oldest.
- R8: While `rx_off` is high, serial receive pushes are ignored, neither stored nor flagged as overrun.
- R9: While `rx_read_zero` is high, host receive reads return zero but still consume a sample.
- R10: `tx_dma_req` equals `tx_dma_en` AND `tx_empty`, and `rx_dma_req` equals `rx_dma_en` AND `rx_full`.
- R11: When a direction's autosync input is high and its left and right counts differ by more than one:
  - the next edge cuts the deeper queue back to the shallower count, dropping its newest samples;
  - the direction's resync output pulses for exactly one cycle, in which both counts are equal.
  - With autosync low there is no realignment and no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_mode | input | 2 | Transmit mode: 0/3 zero output, 1 run, 2 collapse to one |
| tx_empty_sel | input | 2 | Transmit low-level threshold select |
| tx_autosync | input | 1 | Transmit left/right realignment enable |
| tx_dma_en | input | 1 | Transmit DMA request enable |
| rx_full_sel | input | 2 | Receive high-level threshold select |
| rx_trim | input | 1 | Collapse receive queues to one sample |
| rx_off | input | 1 | Refuse serial receive pushes |
| rx_read_zero | input | 1 | Host receive reads return zero |
| rx_autosync | input | 1 | Receive left/right realignment enable |
| rx_dma_en | input | 1 | Receive DMA request enable |
| host_txl_wr | input | 1 | Host write, left transmit queue |
| host_txr_wr | input | 1 | Host write, right transmit queue |
| host_txl_data | input | 24 | Left transmit sample |
| host_txr_data | input | 24 | Right transmit sample |
| ser_txl_pop | input | 1 | Serial pop, left transmit queue |
| ser_txr_pop | input | 1 | Serial pop, right transmit queue |
| ser_txl_data | output | 24 | Last popped left transmit sample |
| ser_txr_data | output | 24 | Last popped right transmit sample |
| ser_rxl_push | input | 1 | Serial push, left receive queue |
| ser_rxr_push | input | 1 | Serial push, right receive queue |
| ser_rxl_data | input | 24 | Left received sample |
| ser_rxr_data | input | 24 | Right received sample |
| host_rxl_rd | input | 1 | Host read, left receive queue |
| host_rxr_rd | input | 1 | Host read, right receive queue |
| host_rxl_data | output | 24 | Last read left receive sample |
| host_rxr_data | output | 24 | Last read right receive sample |
| tx_empty | output | 1 | Transmit occupancy at or below threshold |
| tx_dma_req | output | 1 | Transmit DMA request |
| tx_unov | output | 1 | Transmit underrun/overrun pulse |
| tx_resync | output | 1 | Transmit realignment pulse |
| rx_full | output | 1 | Receive occupancy at or above threshold |
| rx_dma_req | output | 1 | Receive DMA request |
| rx_unov | output | 1 | Receive underrun/overrun pulse |
| rx_resync | output | 1 | Receive realignment pulse |

## Verification
A corrupted read or write pointer shows up on the very next pop or read as a sample out of order or a wrong value. The scoreboard, which models every queue as an ordered list, catches this at once. A wrong occupancy count shows first on the threshold outputs, which are combinational from the counts, so the error is visible in the cycle after the bad update. A bad count at the 0 or 16 boundary shows as a missing or spurious error pulse one cycle later. Faulty collapse or realignment logic is exposed by the first one or two reads after the event: they return a sample that should have been dropped, or zero where the oldest sample should have survived.

// File: rtl/audio_fifo_pkg.sv
`timescale 1ns/1ps
package audio_fifo_pkg;

    localparam int SAMPLE_W    = 24;
    localparam int QUEUE_DEPTH = 16;

    typedef enum logic [1:0] {
        TXM_ZERO = 2'd0,
        TXM_RUN  = 2'd1,
        TXM_TRIM = 2'd2,
        TXM_HOLD = 2'd3
    } tx_mode_e;

    // Per-direction controls handed to a left/right queue pair
    typedef struct packed {
        logic hold;      // pop does not consume
        logic zero;      // popped data forced to zero
        logic trim;      // collapse to one sample
        logic autosync;  // realign diverged queues
    } pair_ctrl_t;

    function automatic int unsigned low_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 0;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 12;
        endcase
    endfunction

    function automatic int unsigned high_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 16;
        endcase
    endfunction

endpackage

// File: rtl/sample_queue.sv
`timescale 1ns/1ps
module sample_queue #(
    parameter int SW    = 24,
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [SW-1:0] push_data,
    input  logic          pop,
    input  logic          pop_hold,
    input  logic          pop_zero,
    input  logic          force_en,
    input  logic [CW-1:0] force_cnt,
    output logic [CW-1:0] count,
    output logic [SW-1:0] pop_data,
    output logic          overrun,
    output logic          underrun
);
    localparam int AW = $clog2(DEPTH);

    logic [SW-1:0] mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] cnt;
    logic          take, give, is_empty, is_full;

    always_comb begin
        is_empty = (cnt == '0);
        is_full  = (cnt == CW'(DEPTH));
        take     = pop && !pop_hold && !is_empty && !force_en;
        give     = push && (!is_full || take) && !force_en;
        underrun = pop && !pop_hold && is_empty && !force_en;
        overrun  = push && !give && !force_en;
    end

    always_ff @(posedge clk) begin
        if (give) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr   <= '0;
            wr_ptr   <= '0;
            cnt      <= '0;
            pop_data <= '0;
        end else if (force_en) begin
            // Keep the oldest force_cnt entries; newer ones are dropped
            cnt    <= force_cnt;
            wr_ptr <= rd_ptr + force_cnt[AW-1:0];
        end else begin
            if (give) wr_ptr <= wr_ptr + 1'b1;
            if (take) rd_ptr <= rd_ptr + 1'b1;
            cnt <= cnt + CW'(give) - CW'(take);
            if (pop) pop_data <= (take && !pop_zero) ? mem[rd_ptr] : '0;
        end
    end

    assign count = cnt;

endmodule

// File: rtl/queue_pair.sv
`timescale 1ns/1ps
module queue_pair
    import audio_fifo_pkg::*;
#(
    parameter int SW    = 24,
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    push,     // [0] left, [1] right
    input  logic [1:0]    pop,
    input  logic [SW-1:0] din_l,
    input  logic [SW-1:0] din_r,
    input  pair_ctrl_t    ctrl,
    output logic [CW-1:0] cnt_l,
    output logic [CW-1:0] cnt_r,
    output logic [SW-1:0] dout_l,
    output logic [SW-1:0] dout_r,
    output logic          unov,
    output logic          resync
);
    logic [SW-1:0] din  [2];
    logic [SW-1:0] dout [2];
    logic [CW-1:0] cnt  [2];
    logic [1:0]    ovr, und;
    logic [CW-1:0] gap, target, force_cnt;
    logic          align, force_en;

    assign din[0] = din_l;
    assign din[1] = din_r;

    always_comb begin
        gap       = (cnt[0] > cnt[1]) ? (cnt[0] - cnt[1]) : (cnt[1] - cnt[0]);
        target    = (cnt[0] < cnt[1]) ? cnt[0] : cnt[1];
        align     = ctrl.autosync && (gap > CW'(1)) && !ctrl.trim;
        force_en  = ctrl.trim || align;
        force_cnt = ctrl.trim ? CW'(1) : target;
    end

    for (genvar ch = 0; ch < 2; ch++) begin : g_ch
        sample_queue #(.SW(SW), .DEPTH(DEPTH)) u_q (
            .clk       (clk),
            .rst       (rst),
            .push      (push[ch]),
            .push_data (din[ch]),
            .pop       (pop[ch]),
            .pop_hold  (ctrl.hold),
            .pop_zero  (ctrl.zero),
            .force_en  (force_en),
            .force_cnt (force_cnt),
            .count     (cnt[ch]),
            .pop_data  (dout[ch]),
            .overrun   (ovr[ch]),
            .underrun  (und[ch])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            unov   <= 1'b0;
            resync <= 1'b0;
        end else begin
            unov   <= (|ovr) || (|und);
            resync <= align;
        end
    end

    assign cnt_l  = cnt[0];
    assign cnt_r  = cnt[1];
    assign dout_l = dout[0];
    assign dout_r = dout[1];

endmodule

// File: rtl/stereo_sample_fifo.sv
`timescale 1ns/1ps
module stereo_sample_fifo
    import audio_fifo_pkg::*;
#(
    parameter int SW    = SAMPLE_W,
    parameter int DEPTH = QUEUE_DEPTH
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    tx_mode,
    input  logic [1:0]    tx_empty_sel,
    input  logic          tx_autosync,
    input  logic          tx_dma_en,
    input  logic [1:0]    rx_full_sel,
    input  logic          rx_trim,
    input  logic          rx_off,
    input  logic          rx_read_zero,
    input  logic          rx_autosync,
    input  logic          rx_dma_en,
    input  logic          host_txl_wr,
    input  logic          host_txr_wr,
    input  logic [SW-1:0] host_txl_data,
    input  logic [SW-1:0] host_txr_data,
    input  logic          ser_txl_pop,
    input  logic          ser_txr_pop,
    output logic [SW-1:0] ser_txl_data,
    output logic [SW-1:0] ser_txr_data,
    input  logic          ser_rxl_push,
    input  logic          ser_rxr_push,
    input  logic [SW-1:0] ser_rxl_data,
    input  logic [SW-1:0] ser_rxr_data,
    input  logic          host_rxl_rd,
    input  logic          host_rxr_rd,
    output logic [SW-1:0] host_rxl_data,
    output logic [SW-1:0] host_rxr_data,
    output logic          tx_empty,
    output logic          tx_dma_req,
    output logic          tx_unov,
    output logic          tx_resync,
    output logic          rx_full,
    output logic          rx_dma_req,
    output logic          rx_unov,
    output logic          rx_resync
);
    localparam int CW = $clog2(DEPTH + 1);

    tx_mode_e      mode;
    pair_ctrl_t    tx_ctrl, rx_ctrl;
    logic [CW-1:0] tx_cnt_l, tx_cnt_r, rx_cnt_l, rx_cnt_r;
    logic [CW-1:0] tx_level, rx_level;

    always_comb begin
        mode             = tx_mode_e'(tx_mode);
        tx_ctrl.hold     = (mode == TXM_ZERO) || (mode == TXM_HOLD);
        tx_ctrl.zero     = tx_ctrl.hold;
        tx_ctrl.trim     = (mode == TXM_TRIM);
        tx_ctrl.autosync = tx_autosync;
        rx_ctrl.hold     = 1'b0;
        rx_ctrl.zero     = rx_read_zero;
        rx_ctrl.trim     = rx_trim;
        rx_ctrl.autosync = rx_autosync;
    end

    queue_pair #(.SW(SW), .DEPTH(DEPTH)) u_tx (
        .clk    (clk),
        .rst    (rst),
        .push   ({host_txr_wr, host_txl_wr}),
        .pop    ({ser_txr_pop, ser_txl_pop}),
        .din_l  (host_txl_data),
        .din_r  (host_txr_data),
        .ctrl   (tx_ctrl),
        .cnt_l  (tx_cnt_l),
        .cnt_r  (tx_cnt_r),
        .dout_l (ser_txl_data),
        .dout_r (ser_txr_data),
        .unov   (tx_unov),
        .resync (tx_resync)
    );

    queue_pair #(.SW(SW), .DEPTH(DEPTH)) u_rx (
        .clk    (clk),
        .rst    (rst),
        .push   ({ser_rxr_push && !rx_off, ser_rxl_push && !rx_off}),
        .pop    ({host_rxr_rd, host_rxl_rd}),
        .din_l  (ser_rxl_data),
        .din_r  (ser_rxr_data),
        .ctrl   (rx_ctrl),
        .cnt_l  (rx_cnt_l),
        .cnt_r  (rx_cnt_r),
        .dout_l (host_rxl_data),
        .dout_r (host_rxr_data),
        .unov   (rx_unov),
        .resync (rx_resync)
    );

    always_comb begin
        tx_level   = CW'(low_level(tx_empty_sel));
        rx_level   = CW'(high_level(rx_full_sel));
        tx_empty   = (tx_cnt_l <= tx_level) && (tx_cnt_r <= tx_level);
        rx_full    = (rx_cnt_l >= rx_level) && (rx_cnt_r >= rx_level);
        tx_dma_req = tx_dma_en && tx_empty;
        rx_dma_req = rx_dma_en && rx_full;
    end

endmodule

// File: rtl/sfifo_checker.sv
`timescale 1ns/1ps
module sfifo_checker #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    tx_mode,
    input logic [1:0]    tx_empty_sel,
    input logic          tx_empty,
    input logic          ser_txl_pop,
    input logic          tx_unov,
    input logic [CW-1:0] tx_cnt_l,
    input logic [CW-1:0] tx_cnt_r,
    input logic          rx_trim,
    input logic [1:0]    rx_full_sel,
    input logic          rx_full,
    input logic          rx_off,
    input logic [CW-1:0] rx_cnt_l,
    input logic [CW-1:0] rx_cnt_r,
    input logic          rx_autosync,
    input logic          rx_resync,
    input logic          rx_dma_req
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (tx_cnt_l <= CW'(DEPTH)) && (rx_cnt_r <= CW'(DEPTH))); // R5

    AST_TX_UNDERRUN_PULSE: assert property (@(posedge clk) disable iff (rst)
        (ser_txl_pop && tx_mode == 2'd1 && tx_cnt_l == '0 && tx_cnt_r <= CW'(1))
        |=> tx_unov); // R5

    AST_TX_TRIM_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (tx_mode == 2'd2) |=> (tx_empty_sel == 2'd0 || tx_empty)); // R6

    AST_RX_TRIM_FULL: assert property (@(posedge clk) disable iff (rst)
        rx_trim |=> (rx_full_sel != 2'd0 || rx_full)); // R7

    AST_RX_OFF_NO_GROWTH: assert property (@(posedge clk) disable iff (rst)
        (rx_off && !rx_trim) |=> (rx_cnt_l <= $past(rx_cnt_l))); // R8

    AST_RX_DMA_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
        rx_dma_req |-> rx_full); // R10

    AST_RESYNC_EQUAL: assert property (@(posedge clk) disable iff (rst)
        rx_resync |-> (rx_cnt_l == rx_cnt_r)); // R11

    AST_NO_RESYNC_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !rx_autosync |=> !rx_resync); // R11

endmodule

bind stereo_sample_fifo sfifo_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .tx_mode      (tx_mode),
    .tx_empty_sel (tx_empty_sel),
    .tx_empty     (tx_empty),
    .ser_txl_pop  (ser_txl_pop),
    .tx_unov      (tx_unov),
    .tx_cnt_l     (tx_cnt_l),
    .tx_cnt_r     (tx_cnt_r),
    .rx_trim      (rx_trim),
    .rx_full_sel  (rx_full_sel),
    .rx_full      (rx_full),
    .rx_off       (rx_off),
    .rx_cnt_l     (rx_cnt_l),
    .rx_cnt_r     (rx_cnt_r),
    .rx_autosync  (rx_autosync),
    .rx_resync    (rx_resync),
    .rx_dma_req   (rx_dma_req)
);

// File: tb/sim_stereo_sample_fifo.sv
`timescale 1ns/1ps
module sim_stereo_sample_fifo;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  tx_mode = 2'd1, tx_empty_sel = 2'd0, rx_full_sel = 2'd0;
    logic        tx_autosync = 0, tx_dma_en = 0, rx_trim = 0, rx_off = 0;
    logic        rx_read_zero = 0, rx_autosync = 0, rx_dma_en = 0;
    logic        host_txl_wr = 0, host_txr_wr = 0, ser_txl_pop = 0, ser_txr_pop = 0;
    logic        ser_rxl_push = 0, ser_rxr_push = 0, host_rxl_rd = 0, host_rxr_rd = 0;
    logic [23:0] host_txl_data = '0, host_txr_data = '0, ser_rxl_data = '0, ser_rxr_data = '0;
    logic [23:0] ser_txl_data, ser_txr_data, host_rxl_data, host_rxr_data;
    logic        tx_empty, tx_dma_req, tx_unov, tx_resync;
    logic        rx_full, rx_dma_req, rx_unov, rx_resync;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Scoreboard: expected contents of each queue
    logic [23:0] txq_l[$], txq_r[$], rxq_l[$], rxq_r[$];

    stereo_sample_fifo u0 (.*);

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tx_write(input logic [23:0] l, input logic [23:0] r, input bit dl = 1, input bit dr = 1);
        @(negedge clk);
        host_txl_wr = dl; host_txr_wr = dr; host_txl_data = l; host_txr_data = r;
        if (dl && txq_l.size() < 16) txq_l.push_back(l);
        if (dr && txq_r.size() < 16) txq_r.push_back(r);
        @(negedge clk);
        host_txl_wr = 0; host_txr_wr = 0;
    endtask

    task automatic tx_pop(input string req);
        logic [23:0] el, er;
        el = '0; er = '0;
        @(negedge clk);
        ser_txl_pop = 1; ser_txr_pop = 1;
        if (tx_mode == 2'd1) begin
            if (txq_l.size() > 0) el = txq_l.pop_front();
            if (txq_r.size() > 0) er = txq_r.pop_front();
        end
        @(negedge clk);
        ser_txl_pop = 0; ser_txr_pop = 0;
        chk({req, " tx left"}, ser_txl_data, el);
        chk({req, " tx right"}, ser_txr_data, er);
    endtask

    task automatic rx_push(input logic [23:0] l, input logic [23:0] r, input bit dl = 1, input bit dr = 1);
        @(negedge clk);
        ser_rxl_push = dl; ser_rxr_push = dr; ser_rxl_data = l; ser_rxr_data = r;
        if (!rx_off && dl && rxq_l.size() < 16) rxq_l.push_back(l);
        if (!rx_off && dr && rxq_r.size() < 16) rxq_r.push_back(r);
        @(negedge clk);
        ser_rxl_push = 0; ser_rxr_push = 0;
    endtask

    task automatic rx_read(input string req);
        logic [23:0] el, er;
        el = '0; er = '0;
        @(negedge clk);
        host_rxl_rd = 1; host_rxr_rd = 1;
        if (rxq_l.size() > 0) el = rxq_l.pop_front();
        if (rxq_r.size() > 0) er = rxq_r.pop_front();
        if (rx_read_zero) begin el = '0; er = '0; end
        @(negedge clk);
        host_rxl_rd = 0; host_rxr_rd = 0;
        chk({req, " rx left"}, host_rxl_data, el);
        chk({req, " rx right"}, host_rxr_data, er);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 tx_empty", tx_empty, 1);
        chk("R1 rx_full", rx_full, 0);
        chk("R1 ser_txl_data", ser_txl_data, 0);
        chk("R1 host_rxr_data", host_rxr_data, 0);
        chk("R1 tx_unov", tx_unov, 0);
        chk("R1 rx_resync", rx_resync, 0);

        // R2 ordering through the transmit side
        for (int i = 0; i < 3; i++) tx_write(24'hA00000 + 24'(i), 24'hB00000 + 24'(i));
        for (int i = 0; i < 3; i++) tx_pop("R2");
        // R5 underrun returns zero and pulses
        tx_pop("R5 underrun");
        chk("R5 tx_unov after empty pop", tx_unov, 1);
        @(negedge clk);
        chk("R5 tx_unov single cycle", tx_unov, 0);

        // R3 thresholds, R10 DMA gating
        tx_empty_sel = 2'd1;
        for (int i = 0; i < 4; i++) tx_write(24'h100 + 24'(i), 24'h200 + 24'(i));
        chk("R3 sel1 at 4", tx_empty, 1);
        tx_dma_en = 1; #1;
        chk("R10 tx_dma_req on", tx_dma_req, 1);
        tx_write(24'h104, 24'h204);
        chk("R3 sel1 at 5", tx_empty, 0);
        chk("R10 tx_dma_req follows flag", tx_dma_req, 0);
        tx_dma_en = 0;
        tx_empty_sel = 2'd2; #1;
        chk("R3 sel2 at 5", tx_empty, 1);
        tx_empty_sel = 2'd0; #1;
        chk("R3 sel0 at 5", tx_empty, 0);

        // R5 overflow at 16 entries
        for (int i = 5; i < 16; i++) tx_write(24'h100 + 24'(i), 24'h200 + 24'(i));
        chk("R5 no overrun at 16", tx_unov, 0);
        tx_write(24'hDEAD01, 24'hDEAD02);
        chk("R5 overrun pulse", tx_unov, 1);
        tx_empty_sel = 2'd3; #1;
        chk("R3 sel3 at 16", tx_empty, 0);
        for (int i = 0; i < 16; i++) tx_pop("R5 R2 drain");
        chk("R3 empty after drain", tx_empty, 1);

        // R6 zero modes do not consume
        tx_write(24'hC1, 24'hD1);
        tx_write(24'hC2, 24'hD2);
        tx_mode = 2'd0;
        tx_pop("R6 mode0");
        chk("R6 no underrun in mode0", tx_unov, 0);
        tx_mode = 2'd3;
        tx_pop("R6 mode3");
        tx_mode = 2'd1;
        tx_pop("R6 resume");
        tx_pop("R6 resume");
        // R6 collapse to one sample
        for (int i = 0; i < 3; i++) tx_write(24'hE0 + 24'(i), 24'hF0 + 24'(i));
        @(negedge clk); tx_mode = 2'd2;
        @(negedge clk); tx_mode = 2'd1;
        while (txq_l.size() > 1) void'(txq_l.pop_back());
        while (txq_r.size() > 1) void'(txq_r.pop_back());
        tx_pop("R6 trim keeps oldest");
        tx_pop("R6 trim leaves one");

        // R4 receive thresholds, R10
        rx_full_sel = 2'd0; #1;
        chk("R4 sel0 empty", rx_full, 0);
        rx_push(24'h11, 24'h21);
        chk("R4 sel0 one sample", rx_full, 1);
        rx_dma_en = 1; #1;
        chk("R10 rx_dma_req", rx_dma_req, 1);
        rx_dma_en = 0;
        for (int i = 2; i < 5; i++) rx_push(24'h10 + 24'(i), 24'h20 + 24'(i));
        rx_full_sel = 2'd1; #1;
        chk("R4 sel1 at 4", rx_full, 1);
        rx_full_sel = 2'd2; #1;
        chk("R4 sel2 at 4", rx_full, 0);
        for (int i = 0; i < 4; i++) rx_read("R2 rx order");

        // R8 receive off
        rx_off = 1;
        rx_push(24'h55, 24'h66);
        chk("R8 no overrun when off", rx_unov, 0);
        rx_full_sel = 2'd0; #1;
        chk("R8 nothing stored", rx_full, 0);
        rx_off = 0;
        rx_read("R8 read after off");

        // R9 read-zero still consumes
        rx_push(24'h71, 24'h81);
        rx_push(24'h72, 24'h82);
        rx_read_zero = 1;
        rx_read("R9 masked");
        rx_read_zero = 0;
        rx_read("R9 consumed");

        // R7 receive collapse
        for (int i = 0; i < 3; i++) rx_push(24'h90 + 24'(i), 24'hA0 + 24'(i));
        @(negedge clk); rx_trim = 1;
        @(negedge clk); rx_trim = 0;
        while (rxq_l.size() > 1) void'(rxq_l.pop_back());
        while (rxq_r.size() > 1) void'(rxq_r.pop_back());
        rx_read("R7 keeps oldest");
        rx_read("R7 leaves one");

        // R4 level 16, R5 receive overrun
        rx_full_sel = 2'd3;
        for (int i = 0; i < 15; i++) rx_push(24'h300 + 24'(i), 24'h400 + 24'(i));
        chk("R4 sel3 at 15", rx_full, 0);
        rx_push(24'h30F, 24'h40F);
        chk("R4 sel3 at 16", rx_full, 1);
        rx_push(24'hBAD, 24'hBAD);
        chk("R5 rx overrun pulse", rx_unov, 1);
        for (int i = 0; i < 16; i++) rx_read("R5 R2 rx drain");

        // R11 realignment
        rx_push(24'h501, 24'h601);
        rx_push(24'h502, 24'h0, 1, 0);
        rx_push(24'h503, 24'h0, 1, 0);
        @(negedge clk);
        chk("R11 no pulse with autosync off", rx_resync, 0);
        rx_autosync = 1;
        @(negedge clk);
        chk("R11 resync pulse", rx_resync, 1);
        while (rxq_l.size() > rxq_r.size()) void'(rxq_l.pop_back());
        rx_autosync = 0;
        @(negedge clk);
        chk("R11 pulse one cycle", rx_resync, 0);
        rx_read("R11 aligned pair");
        rx_read("R11 newest dropped");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule